// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one programmable performance-monitoring counter for a processor core. Every clock it receives a small count of how many times the selected event happened in that cycle, the same count from the sibling hardware thread, and the privilege level the core is running at. A configuration word decides which cycles qualify. It holds two privilege enables, an invert bit, an edge-detect bit, an any-thread bit and an 8-bit threshold. The block then advances a 48-bit count and raises a sticky overflow flag when that count wraps.

Software writes the configuration with a one-cycle strobe. It can preload the count, clear the overflow flag and stop all counting with a global enable. With a zero threshold the counter behaves as an ordinary adder of the raw occurrence count. With a nonzero threshold it counts one per qualifying cycle, or one per rising edge of the qualifying condition. Asking for edge detection with a zero threshold is an illegal setting. The block reports it on an error output and does not count while that setting is in place.

Top module: `perf_event_counter`

## Requirements
- R1: Privilege level 0 (privLevel == 2'd0) counts only when the kernel enable is set. Levels 1, 2 and 3 count only when the user enable is set. A cycle whose level is not enabled adds nothing.
- R2: With a nonzero threshold, an enabled cycle whose occurrence count is greater than or equal to the threshold adds exactly 1. Any other cycle adds 0.
- R3: With a zero threshold, every enabled cycle adds its raw occurrence count. The invert bit has no effect in this mode.
- R4: With invert set and a nonzero threshold, an enabled cycle adds 1 exactly when its occurrence count is below the threshold.
- R5: With edge detect set and a nonzero threshold, the count advances by 1 only in a qualifying cycle whose previous cycle did not qualify. The previous-cycle history is cleared by a configuration write and by any cycle with the global enable low.
- R6: With any-thread set, the occurrence count is the sum of the own-thread and sibling-thread counts, taken before the threshold compare or the raw add.
- R7: While the stored configuration has edge detect set with a zero threshold, cfgError reads 1 and the count never advances from events.
- R8: loadEn replaces the count with loadValue at the next edge. This happens whatever the global enable is, and it takes precedence over an increment in the same cycle.
- R9: An increment that carries past the top count value wraps the count modulo 2^48 and sets overflow. Overflow stays set until ovfClr. A wrap in the same cycle as ovfClr leaves it set.
- R10: With globalEn low, count and overflow hold their values apart from loads and overflow clears.
- R11: A configuration written with cfgWrEn takes effect from the following cycle. The write cycle itself adds nothing to the count.
- R12: After reset the count, the overflow flag, cfgError and every configuration field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Writes the configuration fields below |
| cfgUserEn | input | 1 | Count at privilege levels 1 to 3 |
| cfgKernEn | input | 1 | Count at privilege level 0 |
| cfgInvert | input | 1 | Invert the threshold compare |
| cfgEdge | input | 1 | Count rising edges of the qualifying condition |
| cfgAnyThread | input | 1 | Add the sibling thread's occurrences |
| cfgThresh | input | 8 | Threshold, 0 selects raw add |
| globalEn | input | 1 | Global counting enable |
| evtCount | input | 3 | Own-thread event occurrences this cycle |
| siblingCount | input | 3 | Sibling-thread event occurrences this cycle |
| privLevel | input | 2 | Current privilege level, 0 is kernel |
| loadEn | input | 1 | Load the count from loadValue |
| loadValue | input | 48 | Value to load |
| ovfClr | input | 1 | Clear the overflow flag |
| count | output | 48 | Current count |
| overflow | output | 1 | Sticky wrap flag |
| cfgError | output | 1 | Illegal edge-with-zero-threshold setting stored |

## Verification
Almost every fault in the qualification logic shows as a count that differs from the reference one clock later. Examples are a stale configuration field, a stuck edge-history bit, or a wrong operand in the threshold compare. Because of that, comparing count every cycle localises a fault to the cycle that caused it. A history bit that is not cleared on a write or a disable is different. It only shows on the first qualifying cycle after that event, so the stimulus forces such cycles right after each write and each disable. Overflow faults stay hidden until a wrap, so the count is preloaded just below the top value and then driven across it under clear and disable conditions.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int EVT_W  = 3;
  localparam int OCC_W  = EVT_W + 1;
  localparam int THR_W  = 8;
  localparam int PRIV_W = 2;

  typedef struct packed {
    logic             userEn;
    logic             kernEn;
    logic             invert;
    logic             edgeDet;
    logic             anyThread;
    logic [THR_W-1:0] thresh;
  } pecCfg_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [OCC_W-1:0] incAmt;
    logic             loadNow;
    logic             clrOvf;
  } pecStrobe_t;
endpackage

// File: rtl/pec_ctrl.sv
module pec_ctrl
  import pec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  pecCfg_t           cfgIn,
  input  logic              globalEn,
  input  logic [EVT_W-1:0]  evtCount,
  input  logic [EVT_W-1:0]  siblingCount,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              loadEn,
  input  logic              ovfClr,
  output pecStrobe_t        strobe,
  output logic              cfgError
);
  pecCfg_t          cfgQ;
  logic             prevQual;
  logic [OCC_W-1:0] occ;
  logic             privOk;
  logic             threshZero;
  logic             cfgBad;
  logic             meetsThresh;
  logic             qualNow;
  logic             active;
  logic [OCC_W-1:0] rawInc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgIn;
  end

  always_comb begin
    if (cfgQ.anyThread) occ = {1'b0, evtCount} + {1'b0, siblingCount};
    else                occ = {1'b0, evtCount};
  end

  assign privOk      = (privLevel == '0) ? cfgQ.kernEn : cfgQ.userEn;
  assign threshZero  = (cfgQ.thresh == '0);
  assign cfgBad      = cfgQ.edgeDet & threshZero;
  assign meetsThresh = ({{(THR_W-OCC_W){1'b0}}, occ} >= cfgQ.thresh);
  assign qualNow     = privOk & (threshZero ? (occ != '0) : (meetsThresh ^ cfgQ.invert));
  assign active      = globalEn & ~cfgWrEn & ~cfgBad;

  always_comb begin
    if (threshZero)        rawInc = privOk ? occ : '0;
    else if (cfgQ.edgeDet) rawInc = {{(OCC_W-1){1'b0}}, qualNow & ~prevQual};
    else                   rawInc = {{(OCC_W-1){1'b0}}, qualNow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    prevQual <= 1'b0;
    else if (globalEn && !cfgWrEn) prevQual <= qualNow;
    else                           prevQual <= 1'b0;
  end

  assign strobe.incAmt  = active ? rawInc : '0;
  assign strobe.loadNow = loadEn;
  assign strobe.clrOvf  = ovfClr;
  assign cfgError       = cfgBad;

  assert_err_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfgError |-> (strobe.incAmt == '0));

  assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgQ.edgeDet && strobe.incAmt != '0) |=> (strobe.incAmt == '0));

  assert_kernel_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (privLevel == '0 && !cfgQ.kernEn) |-> (strobe.incAmt == '0));

  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWrEn |-> (strobe.incAmt == '0));
endmodule

// File: rtl/pec_datapath.sv
module pec_datapath
  import pec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pecStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam int PAD_W = CNT_W - OCC_W;

  logic [CNT_W:0] sum;
  logic           wrapNow;

  assign sum     = {1'b0, count} + {1'b0, {PAD_W{1'b0}}, strobe.incAmt};
  assign wrapNow = ~strobe.loadNow & sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (strobe.loadNow) count <= loadValue;
    else                     count <= sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else        overflow <= (overflow & ~strobe.clrOvf) | wrapNow;
  end

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !strobe.clrOvf) |=> overflow);

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadNow |=> (count == $past(loadValue)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.incAmt == '0 && !strobe.loadNow) |=> $stable(count));
endmodule

// File: rtl/perf_event_counter.sv
module perf_event_counter
  import pec_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic              cfgUserEn,
  input  logic              cfgKernEn,
  input  logic              cfgInvert,
  input  logic              cfgEdge,
  input  logic              cfgAnyThread,
  input  logic [THR_W-1:0]  cfgThresh,
  input  logic              globalEn,
  input  logic [EVT_W-1:0]  evtCount,
  input  logic [EVT_W-1:0]  siblingCount,
  input  logic [PRIV_W-1:0] privLevel,
  input  logic              loadEn,
  input  logic [CNT_W-1:0]  loadValue,
  input  logic              ovfClr,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              cfgError
);
  pecCfg_t    cfgIn;
  pecStrobe_t strobe;

  assign cfgIn = '{userEn: cfgUserEn, kernEn: cfgKernEn, invert: cfgInvert,
                   edgeDet: cfgEdge, anyThread: cfgAnyThread, thresh: cfgThresh};

  pec_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgWrEn      (cfgWrEn),
    .cfgIn        (cfgIn),
    .globalEn     (globalEn),
    .evtCount     (evtCount),
    .siblingCount (siblingCount),
    .privLevel    (privLevel),
    .loadEn       (loadEn),
    .ovfClr       (ovfClr),
    .strobe       (strobe),
    .cfgError     (cfgError)
  );

  pec_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .loadValue (loadValue),
    .count     (count),
    .overflow  (overflow)
  );
endmodule

// File: tb/test_perf_event_counter.sv
module test_perf_event_counter;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfgWrEn, cfgUserEn, cfgKernEn, cfgInvert, cfgEdge, cfgAnyThread;
  logic [7:0]    cfgThresh;
  logic          globalEn;
  logic [2:0]    evtCount, siblingCount;
  logic [1:0]    privLevel;
  logic          loadEn, ovfClr;
  logic [CW-1:0] loadValue;
  logic [CW-1:0] count;
  logic          overflow, cfgError;

  always #5 clk = ~clk;

  perf_event_counter i_perf_event_counter (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgUserEn(cfgUserEn),
    .cfgKernEn(cfgKernEn), .cfgInvert(cfgInvert), .cfgEdge(cfgEdge),
    .cfgAnyThread(cfgAnyThread), .cfgThresh(cfgThresh), .globalEn(globalEn),
    .evtCount(evtCount), .siblingCount(siblingCount), .privLevel(privLevel),
    .loadEn(loadEn), .loadValue(loadValue), .ovfClr(ovfClr),
    .count(count), .overflow(overflow), .cfgError(cfgError)
  );

  int    nRun = 0;
  int    nFail = 0;
  bit    finished = 0;
  string curReq = "R12";

  // reference model state
  logic [CW-1:0] mCount;
  logic          mOvf, mU, mK, mI, mE, mA, mPrev;
  logic [7:0]    mTh;

  task automatic check(string req, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void modelStep();
    int occ, inc;
    logic privOk, qual, bad;
    logic [CW:0] sum;
    logic wrap;
    occ    = mA ? int'(evtCount) + int'(siblingCount) : int'(evtCount);
    privOk = (privLevel == 2'd0) ? mK : mU;
    bad    = mE && (mTh == 8'd0);
    if (mTh == 8'd0) qual = privOk && (occ != 0);
    else             qual = privOk && ((occ >= int'(mTh)) != mI);
    inc = 0;
    if (globalEn && !cfgWrEn && !bad) begin
      if (mTh == 8'd0) inc = privOk ? occ : 0;
      else if (mE)     inc = (qual && !mPrev) ? 1 : 0;
      else             inc = qual ? 1 : 0;
    end
    mPrev = (globalEn && !cfgWrEn) ? qual : 1'b0;
    if (cfgWrEn) begin
      mU = cfgUserEn; mK = cfgKernEn; mI = cfgInvert;
      mE = cfgEdge;   mA = cfgAnyThread; mTh = cfgThresh;
    end
    wrap = 1'b0;
    if (loadEn) mCount = loadValue;
    else begin
      sum    = {1'b0, mCount} + (CW+1)'(inc);
      wrap   = sum[CW];
      mCount = sum[CW-1:0];
    end
    mOvf = (mOvf && !ovfClr) || wrap;
  endfunction

  task automatic compareAll();
    check(curReq, "count", longint'(count), longint'(mCount));
    check(curReq, "overflow", longint'(overflow), longint'(mOvf));
    check(curReq, "cfgError", longint'(cfgError), longint'(mE && mTh == 8'd0));
  endtask

  task automatic tick();
    modelStep();
    @(posedge clk);
    #1;
    compareAll();
    cfgWrEn = 1'b0; loadEn = 1'b0; ovfClr = 1'b0;
  endtask

  task automatic writeCfg(logic u, logic k, logic i, logic e, logic a, logic [7:0] th);
    cfgWrEn = 1'b1; cfgUserEn = u; cfgKernEn = k; cfgInvert = i;
    cfgEdge = e; cfgAnyThread = a; cfgThresh = th;
    tick();
  endtask

  task automatic randCycles(int n, bit randPriv);
    for (int c = 0; c < n; c++) begin
      evtCount     = 3'($urandom_range(0, 7));
      siblingCount = 3'($urandom_range(0, 7));
      privLevel    = randPriv ? 2'($urandom_range(0, 3)) : privLevel;
      tick();
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst_n = 1'b0; cfgWrEn = 0; cfgUserEn = 0; cfgKernEn = 0; cfgInvert = 0;
    cfgEdge = 0; cfgAnyThread = 0; cfgThresh = 0; globalEn = 0;
    evtCount = 0; siblingCount = 0; privLevel = 0; loadEn = 0; ovfClr = 0;
    loadValue = '0;
    mCount = '0; mOvf = 0; mU = 0; mK = 0; mI = 0; mE = 0; mA = 0; mTh = 0; mPrev = 0;
    repeat (3) @(posedge clk);
    #1;
    // R12: reset state
    check("R12", "count", longint'(count), 0);
    check("R12", "overflow", longint'(overflow), 0);
    check("R12", "cfgError", longint'(cfgError), 0);
    rst_n = 1'b1;
    globalEn = 1'b1;
    // R12: cleared configuration counts nothing
    evtCount = 3'd7; tick();

    // R3: raw add, invert has no effect
    curReq = "R3";
    writeCfg(1, 1, 0, 0, 0, 8'd0);
    randCycles(30, 1);
    writeCfg(1, 1, 1, 0, 0, 8'd0);
    randCycles(30, 1);

    // R1: privilege filtering
    curReq = "R1";
    writeCfg(1, 0, 0, 0, 0, 8'd0);
    randCycles(30, 1);
    writeCfg(0, 1, 0, 0, 0, 8'd0);
    randCycles(30, 1);
    privLevel = 2'd0; evtCount = 3'd5; tick();
    privLevel = 2'd3; evtCount = 3'd5; tick();

    // R2: threshold compare, including exact-equal boundary
    curReq = "R2";
    writeCfg(1, 1, 0, 0, 0, 8'd3);
    evtCount = 3'd3; tick();
    evtCount = 3'd2; tick();
    randCycles(40, 1);
    writeCfg(1, 1, 0, 0, 0, 8'd255);
    randCycles(10, 0);

    // R4: invert
    curReq = "R4";
    writeCfg(1, 1, 1, 0, 0, 8'd4);
    evtCount = 3'd4; tick();
    evtCount = 3'd3; tick();
    randCycles(40, 1);

    // R5: edge detect with history clears
    curReq = "R5";
    writeCfg(1, 1, 0, 1, 0, 8'd2);
    evtCount = 3'd6; repeat (4) tick();
    evtCount = 3'd0; tick();
    evtCount = 3'd6; repeat (2) tick();
    writeCfg(1, 1, 0, 1, 0, 8'd2);
    tick();
    globalEn = 1'b0; tick();
    globalEn = 1'b1; tick(); tick();
    randCycles(40, 1);

    // R6: any-thread sum
    curReq = "R6";
    writeCfg(1, 1, 0, 0, 1, 8'd9);
    evtCount = 3'd5; siblingCount = 3'd4; tick();
    evtCount = 3'd5; siblingCount = 3'd3; tick();
    randCycles(30, 1);
    writeCfg(1, 1, 0, 0, 1, 8'd0);
    randCycles(30, 1);

    // R7: illegal edge setting
    curReq = "R7";
    writeCfg(1, 1, 0, 1, 0, 8'd0);
    check("R7", "cfgError direct", longint'(cfgError), 1);
    randCycles(20, 1);

    // R11: writes while events are active
    curReq = "R11";
    writeCfg(1, 1, 0, 0, 0, 8'd0);
    for (int w = 0; w < 10; w++) begin
      evtCount = 3'd7;
      writeCfg(1, 1, 0, 0, 0, 8'(w % 3));
      tick();
    end

    // R8: load, precedence over increment
    curReq = "R8";
    writeCfg(1, 1, 0, 0, 0, 8'd0);
    evtCount = 3'd7; privLevel = 2'd1;
    loadEn = 1'b1; loadValue = 48'h0000_1234_5678; tick();
    check("R8", "count direct", longint'(count), longint'(48'h0000_1234_5678));
    tick();

    // R9: wrap and sticky overflow
    curReq = "R9";
    loadEn = 1'b1; loadValue = {CW{1'b1}} - 48'd3; tick();
    evtCount = 3'd7; tick();
    check("R9", "overflow direct", longint'(overflow), 1);
    randCycles(5, 0);
    ovfClr = 1'b1; evtCount = 3'd0; tick();
    loadEn = 1'b1; loadValue = {CW{1'b1}}; tick();
    ovfClr = 1'b1; evtCount = 3'd1; tick();
    check("R9", "set wins over clear", longint'(overflow), 1);

    // R10: global disable holds
    curReq = "R10";
    globalEn = 1'b0;
    randCycles(20, 1);
    ovfClr = 1'b1; tick();
    loadEn = 1'b1; loadValue = 48'd77; tick();
    randCycles(10, 1);
    globalEn = 1'b1;
    randCycles(10, 1);

    finishRun();
  end
endmodule